// File: doc/BRIEF.md
# PHY Management Register Model

This block is a register-level model of the management space of a 10/100 Ethernet PHY. A host reaches it through a parallel command interface. Each command carries a PHY address, a register index, 16-bit write data and one write or read strobe. The block holds sixteen 16-bit registers. It loads power-on defaults and supports a self-reset issued through the control register. The status and identifier registers cannot be written.

A link-up input drives the link bit of the status register and the ability bits of the link-partner register. These bits are rewritten on every change of the input, and again after any reset using the input's current level. Only one PHY address answers commands. Read data is registered, and a link-fail flag is sampled alongside each read. Serial framing on the management wire is outside this block, and so is negotiation timing.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, register 0 reads 0x1000, register 2 reads 0x2000, register 3 reads 0x5C90 and register 4 reads 0x01E1.
- R2: After reset, register 1 reads 0x786C with the link up and 0x7868 with the link down; bit 2 is the link bit. Register 5 reads 0x01E1 with the link up and 0x0000 with the link down.
- R3: Writes to registers 1, 2 and 3 have no effect on their contents.
- R4: A write to register 0 with bit 15 set reloads every register to its reset value. A write to register 0 with bit 15 clear stores the value as written.
- R5: Writes to registers 4 through 15 store the value, and a later read returns it.
- R6: A write to a register index of 16 or above changes no register. A read of such an index on the answering address returns 0x0000.
- R7: Only PHY address 1 responds. A read sent to any other address returns 0xFFFF, and a write sent to any other address is dropped.
- R8: After the link input rises, bit 2 of register 1 is set and register 5 gains bits 0x01E1. After it falls, bit 2 is cleared and register 5 is masked with 0x01FF.
- R9: Read data appears on the first clock edge after the read strobe and holds until the next read.
- R10: On each read, the link-fail output takes the inverse of the link input and holds that value between reads.
- R11: After a self-reset, the link bit and register 5 follow the current level of the link input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_up | input | 1 | Current link state |
| mgmt_phy | input | 5 | Target PHY address of the command |
| mgmt_reg | input | 5 | Target register index |
| mgmt_wdata | input | 16 | Write data |
| mgmt_wr | input | 1 | Write strobe, one cycle |
| mgmt_rd | input | 1 | Read strobe, one cycle |
| mgmt_rdata | output | 16 | Registered read data |
| link_fail | output | 1 | Link-fail flag sampled on each read |

## Verification
All state is visible only through reads. A corrupted register therefore shows up as a wrong value on the read data one edge after the next read of that index. Three kinds of fault do not show up until a read made after a particular event: a default that was never reloaded, a write that was wrongly accepted, and a link edge that was missed. For this reason the bench reads every affected register right after each self-reset, each link transition and each ignored write. It does this with the link both up and down.

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs #(
  parameter int PHY_ADDR  = 1,
  parameter int REG_COUNT = 16,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic [ADDR_W-1:0] mgmt_phy,
  input  logic [ADDR_W-1:0] mgmt_reg,
  input  logic [15:0]       mgmt_wdata,
  input  logic              mgmt_wr,
  input  logic              mgmt_rd,
  output logic [15:0]       mgmt_rdata,
  output logic              link_fail
);
  localparam int IDX_W = $clog2(REG_COUNT);
  localparam logic [ADDR_W:0]   REG_LIM = (ADDR_W+1)'(REG_COUNT);
  localparam logic [ADDR_W-1:0] PHY_SEL = ADDR_W'(PHY_ADDR);
  localparam logic [15:0] CTRL_DEF  = 16'h1000;
  localparam logic [15:0] STAT_DEF  = 16'h7868;
  localparam logic [15:0] ID_HI     = 16'h2000;
  localparam logic [15:0] ID_LO     = 16'h5C90;
  localparam logic [15:0] ABILITY   = 16'h01E1;
  localparam logic [15:0] PART_KEEP = 16'h01FF;
  localparam int LINK_BIT = 2;
  localparam int SRST_BIT = 15;
  localparam int PART_IDX = 5;

  logic [15:0] regs [REG_COUNT];
  logic [15:0] nxt  [REG_COUNT];
  logic        link_q;

  wire             phy_hit  = (mgmt_phy == PHY_SEL);
  wire             in_range = ({1'b0, mgmt_reg} < REG_LIM);
  wire [IDX_W-1:0] idx      = mgmt_reg[IDX_W-1:0];
  wire             wr_hit   = mgmt_wr && phy_hit && in_range;
  wire             soft_rst = wr_hit && (idx == '0) && mgmt_wdata[SRST_BIT];
  wire             reload   = !rst_n || soft_rst;
  wire             link_chg = link_up != link_q;

  function automatic logic [15:0] dflt(int i);
    case (i)
      0:       return CTRL_DEF;
      1:       return STAT_DEF;
      2:       return ID_HI;
      3:       return ID_LO;
      4:       return ABILITY;
      default: return 16'h0000;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < REG_COUNT; i++) nxt[i] = reload ? dflt(i) : regs[i];
    if (wr_hit && !soft_rst) begin
      case (int'(idx))
        1, 2, 3: ;
        default: nxt[idx] = mgmt_wdata;
      endcase
    end
    if (reload || link_chg) begin
      nxt[1][LINK_BIT] = link_up;
      nxt[PART_IDX] = link_up ? (nxt[PART_IDX] | ABILITY) : (nxt[PART_IDX] & PART_KEEP);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < REG_COUNT; i++) regs[i] <= nxt[i];
    link_q <= link_up;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mgmt_rdata <= 16'h0000;
      link_fail  <= 1'b0;
    end else if (mgmt_rd) begin
      mgmt_rdata <= !phy_hit ? 16'hFFFF : (in_range ? regs[idx] : 16'h0000);
      link_fail  <= !link_up;
    end
  end
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
  parameter int PHY_ADDR = 1,
  parameter int ADDR_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_up,
  input logic [ADDR_W-1:0] mgmt_phy,
  input logic              mgmt_rd,
  input logic [15:0]       mgmt_rdata,
  input logic              link_fail
);
  // R7
  foreign_phy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_rd && mgmt_phy != ADDR_W'(PHY_ADDR)) |=> mgmt_rdata == 16'hFFFF);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_rd |=> $stable(mgmt_rdata));
  // R10
  link_fail_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_rd |=> link_fail == !$past(link_up));
  // R10
  link_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_rd |=> $stable(link_fail));
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.PHY_ADDR(PHY_ADDR), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .mgmt_phy(mgmt_phy),
  .mgmt_rd(mgmt_rd), .mgmt_rdata(mgmt_rdata), .link_fail(link_fail));

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, link_up = 1'b1;
  logic [4:0] mgmt_phy = '0, mgmt_reg = '0;
  logic [15:0] mgmt_wdata = '0;
  logic mgmt_wr = 1'b0, mgmt_rd = 1'b0;
  logic [15:0] mgmt_rdata;
  logic link_fail;
  int checks = 0, errors = 0;

  logic [15:0] exp_q[$];
  logic        lf_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  phy_mgmt_regs u_phy_mgmt_regs (.*);

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] phy, logic [4:0] r, logic [15:0] d);
    @(negedge clk);
    mgmt_phy = phy; mgmt_reg = r; mgmt_wdata = d; mgmt_wr = 1'b1;
    @(negedge clk);
    mgmt_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] phy, logic [4:0] r, logic [15:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); lf_q.push_back(!link_up); tag_q.push_back(tag);
    mgmt_phy = phy; mgmt_reg = r; mgmt_rd = 1'b1;
    @(negedge clk);
    mgmt_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_d <= mgmt_rd;

  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read result actual=%h expected=none", mgmt_rdata);
      end else begin
        string t;
        logic lf;
        t = tag_q.pop_front();
        lf = lf_q.pop_front();
        check(t, mgmt_rdata, exp_q.pop_front());
        check({"R10 link_fail ", t}, {15'd0, link_fail}, {15'd0, lf});
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    check("R9 rdata reset", mgmt_rdata, 16'h0000);
    rst_n = 1'b1;
    idle(1);
    rd(1, 0, 16'h1000, "R1 ctrl");
    rd(1, 1, 16'h786C, "R2 status up");
    rd(1, 2, 16'h2000, "R1 id hi");
    rd(1, 3, 16'h5C90, "R1 id lo");
    rd(1, 4, 16'h01E1, "R1 adv");
    rd(1, 5, 16'h01E1, "R2 partner up");
    wr(1, 1, 16'h0000); wr(1, 2, 16'hFFFF); wr(1, 3, 16'h0000);
    rd(1, 1, 16'h786C, "R3 status ro");
    rd(1, 2, 16'h2000, "R3 id hi ro");
    rd(1, 3, 16'h5C90, "R3 id lo ro");
    wr(1, 4, 16'h0061); wr(1, 9, 16'hBEEF); wr(1, 15, 16'h1234);
    rd(1, 4, 16'h0061, "R5 reg4");
    rd(1, 9, 16'hBEEF, "R5 reg9");
    rd(1, 15, 16'h1234, "R5 reg15");
    idle(4);
    check("R9 rdata hold", mgmt_rdata, 16'h1234);
    wr(1, 0, 16'h2100);
    rd(1, 0, 16'h2100, "R4 ctrl store");
    wr(1, 16, 16'hAAAA); wr(1, 31, 16'h5555);
    rd(1, 16, 16'h0000, "R6 out of range read");
    rd(1, 0, 16'h2100, "R6 reg0 untouched");
    rd(1, 15, 16'h1234, "R6 reg15 untouched");
    wr(2, 9, 16'h0000); wr(0, 0, 16'h8000);
    rd(1, 9, 16'hBEEF, "R7 foreign write dropped");
    rd(1, 0, 16'h2100, "R7 foreign reset dropped");
    rd(2, 9, 16'hFFFF, "R7 foreign read");
    rd(0, 1, 16'hFFFF, "R7 foreign read phy0");
    wr(1, 5, 16'hFFFF);
    link_up = 1'b0; idle(2);
    rd(1, 1, 16'h7868, "R8 status down");
    rd(1, 5, 16'h01FF, "R8 partner masked");
    wr(1, 5, 16'h8000);
    link_up = 1'b1; idle(2);
    rd(1, 1, 16'h786C, "R8 status up");
    rd(1, 5, 16'h81E1, "R8 partner set");
    link_up = 1'b0; idle(2);
    wr(1, 0, 16'h8000);
    rd(1, 0, 16'h1000, "R4 soft reset ctrl");
    rd(1, 9, 16'h0000, "R4 soft reset reg9");
    rd(1, 4, 16'h01E1, "R4 soft reset adv");
    rd(1, 1, 16'h7868, "R11 status down");
    rd(1, 5, 16'h0000, "R11 partner down");
    link_up = 1'b1; idle(2);
    wr(1, 9, 16'h5555);
    wr(1, 0, 16'h8000);
    rd(1, 9, 16'h0000, "R4 soft reset reg9 again");
    rd(1, 1, 16'h786C, "R11 status up");
    rd(1, 5, 16'h01E1, "R11 partner up");
    link_up = 1'b0;
    rst_n = 1'b0; idle(2); rst_n = 1'b1;
    rd(1, 1, 16'h7868, "R2 status down after reset");
    rd(1, 5, 16'h0000, "R2 partner down after reset");
    idle(3);
    check("R9 queue drained", 16'(exp_q.size()), 16'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule